// File: doc/BRIEF.md
# Byte Serial Peripheral Engine with Bus-Contention Fallback

This block moves one byte at a time over a four-wire SPI link, either as the bus master or as a selected slave. A single control write sets the enable, the master choice, the direction of the slave-select pin, the level that pin drives when it is an output, the interrupt enable and the MISO drive permission. Software then writes a byte to the data port and later reads the received byte back. A completion flag, mirrored on an interrupt output, marks the end of every byte. Each pin has a separate input, output value and output enable, so the pad ring decides the electrical behaviour.

Only SPI mode 0 is built: SCK idles low, data is sampled on the rising edge and changed on the falling edge, and bits travel most significant first. In master mode SCK runs from a fixed divider whose half period is `HALF` system clocks. In slave mode the incoming SCK, MOSI and slave-select lines pass through two-flop synchronizers before their edges are used.

When the block is a master and its slave-select pin is an input, a low level on that pin means another master has claimed the bus. The block then clears its own master bit, becomes a slave, releases SCK and MOSI, and raises the completion flag. It stays a slave until software sets the master bit again.

Top module: `spi_duplex_core`

## Requirements
- R1: After reset the completion flag, the interrupt, the master bit and every output enable are 0.
- R2: With enable and master set and no byte in flight, a data write starts a transfer: SCK (idle low) gives eight pulses of HALF clocks high and HALF clocks low, and MOSI presents the written byte most significant bit first, stable at each rising SCK edge.
- R3: In master mode the MISO level is sampled on each rising SCK edge. After the eighth falling edge the completion flag is 1 and the data read port returns the sampled byte, first sampled bit in bit 7.
- R4: The interrupt output equals the completion flag ANDed with the interrupt-enable bit.
- R5: The flag clears only when a data read follows a flag read that saw the flag set; a data read alone leaves it at 1.
- R6: A data write while a master transfer is in flight is ignored: the byte on MOSI is the one that started the transfer.
- R7: In master mode with the slave-select direction bit set to output, the pin's output enable is 1, it drives the configured level, and a low level on its input has no effect on the transfer or the master bit.
- R8: In master mode with slave-select as input, a low level on that input clears the master bit, drops SCK and MOSI output enables to 0, stops any transfer and sets the completion flag.
- R9: After that fault the master bit stays 0, even once slave-select returns high, until a control write sets it again.
- R10: In slave mode with slave-select low, each rising SCK edge samples MOSI and each falling edge shifts; after eight bits the flag is 1, the read port returns the received byte, and MISO has carried the byte loaded earlier, most significant bit first.
- R11: The MISO output enable is 1 only in slave mode with the block enabled, slave-select low and the MISO drive bit set; in slave mode SCK, MOSI and slave-select are never driven.
- R12: In slave mode with slave-select high, SCK activity receives nothing and sets no flag; a data write loads the byte to be sent.
- R13: Slave-select rising in the middle of a byte discards the partial byte: no flag is set, the read port keeps its previous value, and the next selected byte is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Writes all control fields below |
| ctl_en | input | 1 | Block enable |
| ctl_mst | input | 1 | Master select |
| ctl_ssdir | input | 1 | Slave-select direction in master mode, 1 = output |
| ctl_ssval | input | 1 | Level driven on slave-select when it is an output |
| ctl_ie | input | 1 | Interrupt enable |
| ctl_misoen | input | 1 | Permission to drive MISO in slave mode |
| mst_q | output | 1 | Current master bit |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Byte to send |
| dat_re | input | 1 | Data read strobe |
| dat_rdata | output | 8 | Last complete received byte |
| flag_re | input | 1 | Status read strobe |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output value |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output value |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Slave-select pin input, active low |
| ss_o | output | 1 | Slave-select pin output value |
| ss_oe | output | 1 | Slave-select output enable |

## Verification
The bench builds the block with HALF = 3, an odd half period, so the divider wraps at a value that is not a power of two and a whole master byte takes only 48 clocks. That short byte lets a fault be injected in mid transfer and a write be poked between SCK edges within a few cycles. The bench plays the far end of the link itself, as slave for master transfers and as master with an eight-clock half period for slave transfers, so the synchronizer delay stays well inside each bit.

// File: rtl/spi_duplex_core.sv
module spi_duplex_core #(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_en,
  input  logic       ctl_mst,
  input  logic       ctl_ssdir,
  input  logic       ctl_ssval,
  input  logic       ctl_ie,
  input  logic       ctl_misoen,
  output logic       mst_q,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  input  logic       dat_re,
  output logic [7:0] dat_rdata,
  input  logic       flag_re,
  output logic       done_flag,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_i,
  output logic       ss_o,
  output logic       ss_oe
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

  logic en, mst, ssdir, ssval, ie, misoen;
  logic busy, sck_r, smp, flag, armed;
  logic [DW-1:0] div;
  logic [2:0] cnt;
  logic [7:0] shreg, rbuf;
  logic [1:0] ss_sy, sck_sy, mosi_sy;
  logic sck_d;

  wire ss_s    = ss_sy[1];
  wire sck_s   = sck_sy[1];
  wire s_rise  = sck_s & ~sck_d;
  wire s_fall  = ~sck_s & sck_d;
  wire fault   = en & mst & ~ssdir & ~ss_s;

  assign mst_q     = mst;
  assign dat_rdata = rbuf;
  assign done_flag = flag;
  assign irq       = flag & ie;
  assign sck_o     = sck_r;
  assign sck_oe    = en & mst;
  assign mosi_o    = shreg[7];
  assign mosi_oe   = en & mst;
  assign miso_o    = shreg[7];
  assign miso_oe   = en & ~mst & ~ss_s & misoen;
  assign ss_o      = ssval;
  assign ss_oe     = en & mst & ssdir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_sy   <= 2'b11;
      sck_sy  <= 2'b00;
      mosi_sy <= 2'b00;
      sck_d   <= 1'b0;
    end else begin
      ss_sy   <= {ss_sy[0], ss_i};
      sck_sy  <= {sck_sy[0], sck_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      sck_d   <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, mst, ssdir, ssval, ie, misoen} <= '0;
      {busy, sck_r, smp, flag, armed} <= '0;
      div   <= '0;
      cnt   <= '0;
      shreg <= '0;
      rbuf  <= '0;
    end else begin
      if (flag_re && flag) armed <= 1'b1;
      if (dat_re && armed) begin
        flag  <= 1'b0;
        armed <= 1'b0;
      end
      if (ctl_we) begin
        en     <= ctl_en;
        mst    <= ctl_mst;
        ssdir  <= ctl_ssdir;
        ssval  <= ctl_ssval;
        ie     <= ctl_ie;
        misoen <= ctl_misoen;
      end else if (fault) begin
        mst  <= 1'b0;
        flag <= 1'b1;
      end
      if (!en || fault) begin
        busy  <= 1'b0;
        sck_r <= 1'b0;
        div   <= '0;
        cnt   <= '0;
      end else if (mst) begin
        if (!busy) begin
          if (dat_we) begin
            shreg <= dat_wdata;
            busy  <= 1'b1;
            div   <= '0;
            cnt   <= '0;
          end
        end else if (div == DIV_LAST) begin
          div   <= '0;
          sck_r <= ~sck_r;
          if (!sck_r) begin
            smp <= miso_i;
          end else begin
            shreg <= {shreg[6:0], smp};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              busy <= 1'b0;
              flag <= 1'b1;
              rbuf <= {shreg[6:0], smp};
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end else begin
        busy  <= 1'b0;
        sck_r <= 1'b0;
        if (ss_s) begin
          cnt <= '0;
          if (dat_we) shreg <= dat_wdata;
        end else if (s_rise) begin
          smp <= mosi_sy[1];
        end else if (s_fall) begin
          shreg <= {shreg[6:0], smp};
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            flag <= 1'b1;
            rbuf <= {shreg[6:0], smp};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_duplex_chk.sv
module spi_duplex_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_we,
  input logic dat_re,
  input logic ss_i,
  input logic mst_q,
  input logic done_flag,
  input logic irq,
  input logic sck_oe,
  input logic miso_oe,
  input logic ss_oe
);
  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);

  assert_flag_drop_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(dat_re));

  assert_ss_drive_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_oe |-> sck_oe);

  assert_fault_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mst_q) && !$past(ctl_we)) |-> done_flag);

  assert_master_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mst_q)) |-> $past(ctl_we));

  assert_miso_needs_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!$past(ss_i, 2) && !sck_oe));
endmodule

bind spi_duplex_core spi_duplex_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .dat_re(dat_re), .ss_i(ss_i),
  .mst_q(mst_q), .done_flag(done_flag), .irq(irq), .sck_oe(sck_oe),
  .miso_oe(miso_oe), .ss_oe(ss_oe)
);

// File: tb/spi_duplex_core_tb_top.sv
module spi_duplex_core_tb_top;
  localparam int HALF = 3;
  localparam int SHP  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_en = 0, ctl_mst = 0, ctl_ssdir = 0, ctl_ssval = 0, ctl_ie = 0, ctl_misoen = 0;
  logic dat_we = 0, dat_re = 0, flag_re = 0;
  logic [7:0] dat_wdata = 8'h00;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_i = 1;
  logic mst_q, done_flag, irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
  logic [7:0] dat_rdata;

  int compared = 0, mismatched = 0;
  bit m_en = 0, m_ie = 0, m_ssdir = 0, m_ssval = 0, m_misoen = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_duplex_core #(.HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_mst(ctl_mst),
    .ctl_ssdir(ctl_ssdir), .ctl_ssval(ctl_ssval), .ctl_ie(ctl_ie), .ctl_misoen(ctl_misoen),
    .mst_q(mst_q), .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re),
    .dat_rdata(dat_rdata), .flag_re(flag_re), .done_flag(done_flag), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock model comparison of pin drive and interrupt
  always @(negedge clk) if (rst_n && !finished) begin
    check("R2 sck_oe", sck_oe, m_en && mst_q);
    check("R8 mosi_oe", mosi_oe, m_en && mst_q);
    check("R4 irq", irq, done_flag && m_ie);
    check("R7 ss_oe", ss_oe, m_en && mst_q && m_ssdir);
    if (ss_oe) check("R7 ss_o", ss_o, m_ssval);
    if (miso_oe) check("R11 miso_oe mode", {mst_q, m_misoen}, 2'b01);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wctl(bit en, bit mst, bit ssdir, bit ssval, bit ie, bit misoen);
    ctl_en = en; ctl_mst = mst; ctl_ssdir = ssdir; ctl_ssval = ssval; ctl_ie = ie; ctl_misoen = misoen;
    ctl_we = 1;
    cyc(1);
    ctl_we = 0;
    m_en = en; m_ie = ie; m_ssdir = ssdir; m_ssval = ssval; m_misoen = misoen;
  endtask

  task automatic wdat(logic [7:0] b);
    dat_wdata = b; dat_we = 1;
    cyc(1);
    dat_we = 0;
  endtask

  task automatic clear_flag();
    flag_re = 1; cyc(1); flag_re = 0;
    dat_re = 1; cyc(1); dat_re = 0;
  endtask

  // bench acts as slave; optional poke writes during the transfer
  task automatic mxfer(logic [7:0] tx, logic [7:0] rx, bit poke, output logic [7:0] cap);
    miso_i = rx[7];
    wdat(tx);
    for (int i = 7; i >= 0; i--) begin
      @(posedge sck_o);
      cap[i] = mosi_o;
      if (poke && i == 4) begin
        #1; dat_wdata = 8'hFF; dat_we = 1;
        @(posedge clk); #1; dat_we = 0;
      end
      @(negedge sck_o);
      if (i > 0) miso_i = rx[i-1];
    end
    cyc(1);
  endtask

  // bench acts as master toward the slave-mode block
  task automatic sxfer(logic [7:0] tx, int nbits, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi_i = tx[i];
      cyc(SHP);
      cap[i] = miso_o;
      sck_i = 1;
      cyc(SHP);
      sck_i = 0;
    end
    cyc(SHP);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1
    check("R1 reset flag/irq/mst", {done_flag, irq, mst_q}, 3'b000);
    check("R1 reset oe", {sck_oe, mosi_oe, miso_oe, ss_oe}, 4'b0000);

    // R2 R3: master transfer
    wctl(1, 1, 1, 1, 0, 0);
    mxfer(8'hA5, 8'h3C, 0, cap);
    check("R2 mosi byte", cap, 8'hA5);
    check("R3 flag", done_flag, 1'b1);
    check("R3 rx byte", dat_rdata, 8'h3C);
    check("R4 irq off", irq, 1'b0);
    // R5
    dat_re = 1; cyc(1); dat_re = 0; cyc(1);
    check("R5 read alone keeps flag", done_flag, 1'b1);
    clear_flag(); cyc(1);
    check("R5 flag cleared", done_flag, 1'b0);

    // R4 R6 R7: ie on, write while busy, ss output held low from outside
    wctl(1, 1, 1, 0, 1, 0);
    check("R7 ss_oe", {ss_oe, ss_o}, 2'b10);
    ss_i = 0;
    mxfer(8'h81, 8'hE7, 1, cap);
    check("R6 busy write ignored", cap, 8'h81);
    check("R7 master kept", mst_q, 1'b1);
    check("R3 rx byte 2", dat_rdata, 8'hE7);
    check("R4 irq on", irq, 1'b1);
    ss_i = 1;
    clear_flag(); cyc(1);
    check("R4 irq after clear", irq, 1'b0);

    // R8 R9: mode fault during a transfer
    wctl(1, 1, 0, 0, 1, 0);
    wdat(8'hF0);
    cyc(5);
    ss_i = 0;
    cyc(4);
    check("R8 master cleared", mst_q, 1'b0);
    check("R8 pins released", {sck_oe, mosi_oe}, 2'b00);
    check("R8 flag and irq", {done_flag, irq}, 2'b11);
    ss_i = 1;
    cyc(6);
    check("R9 still slave", mst_q, 1'b0);
    clear_flag();
    wctl(1, 1, 0, 0, 1, 0);
    cyc(1);
    check("R9 master restored", mst_q, 1'b1);

    // R12: slave, deselected activity ignored
    wctl(1, 0, 0, 0, 0, 1);
    wdat(8'hC3);
    for (int k = 0; k < 8; k++) begin
      mosi_i = k[0]; sck_i = 1; cyc(SHP); sck_i = 0; cyc(SHP);
    end
    check("R12 no flag when deselected", done_flag, 1'b0);
    check("R11 no miso when deselected", miso_oe, 1'b0);
    check("R11 slave drives nothing else", {sck_oe, mosi_oe, ss_oe}, 3'b000);
    // R10 R11
    ss_i = 0; cyc(4);
    check("R11 miso driven", miso_oe, 1'b1);
    sxfer(8'h5A, 8, cap);
    check("R10 rx byte", dat_rdata, 8'h5A);
    check("R10 flag", done_flag, 1'b1);
    check("R10 miso byte", cap, 8'hC3);
    clear_flag();

    // R13: partial byte discarded
    ss_i = 1; cyc(4);
    wdat(8'h0F);
    ss_i = 0; cyc(4);
    sxfer(8'hFF, 4, cap);
    ss_i = 1; cyc(6);
    check("R13 no flag on partial", done_flag, 1'b0);
    check("R13 rx kept", dat_rdata, 8'h5A);
    wdat(8'h96);
    ss_i = 0; cyc(4);
    sxfer(8'h3C, 8, cap);
    check("R13 next byte whole", dat_rdata, 8'h3C);
    check("R12 loaded tx byte", cap, 8'h96);
    clear_flag();

    // R11: drive permission off
    wctl(1, 0, 0, 0, 0, 0);
    cyc(2);
    check("R11 miso off without permission", miso_oe, 1'b0);
    ss_i = 1; cyc(3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule